// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block turns a serial line into bytes. A 16x oversampling tick from an external baud generator paces it. It finds a start bit on a falling edge of the line and confirms it at the middle of the bit. It then samples each data bit, the optional parity bit and the stop bit at their centres, shifting the data in least significant bit first. Frames carry either 8 data bits or 7 data bits. Parity checking is optional in both modes, and a control input selects even or odd parity.

Shifting happens in a private register. The finished byte then moves into a separate holding register, so software can read the previous byte while the next frame arrives. The holding register accepts a byte only after software has re-armed reception with a one-cycle trigger strobe. A frame that ends while the receiver is not armed leaves the older byte in place and raises the overrun flag.

The overrun, parity and framing flags are sticky. Each has its own write-1-to-clear strobe. While receive-enable is low, all three flags are held at zero and the receiver stays idle. The received byte is a plain register with no valid/ready handshake, so nothing can push back on the line. The trigger strobe is the only flow control, and a slow reader sees overruns instead of stalls.

Top module: `serial_rx_flags`

## Requirements
- R1: A start bit is accepted only if the line is still low when sampled 8 ticks after the falling edge is detected. A shorter low pulse produces no frame.
- R2: Data bits are sampled every 16 ticks and stored least significant bit first. A high line level is stored as 1. In 8-bit mode all 8 bits reach `rx_data`.
- R3: When `seven_bit` is 1, 7 data bits are received and bit 7 of the stored byte is 0.
- R4: When `parity_en` is 1, one parity bit follows the data. Parity is even when `parity_odd` is 0 and odd when it is 1. A mismatch sets `parity_err`. The byte is still delivered.
- R5: A stop bit sampled as 0 sets `framing_err`. The frame still completes.
- R6: `rx_done` is high for exactly one cycle per completed frame. `rx_data` and the flags take their new values in that same cycle.
- R7: `rx_data` loads a frame only if a `rx_rearm` pulse has been seen since the last load (or since reset). The load consumes the arming.
- R8: A frame that completes while the receiver is not armed sets `overrun_err` and leaves `rx_data` unchanged.
- R9: Each error flag stays at 1 until its clear strobe is 1 at a clock edge. A clear strobe of 0 has no effect.
- R10: If a flag's error event and its clear strobe fall in the same cycle, the flag ends at 1.
- R11: After reset, and in every cycle after `rx_enable` was low, all flags are 0 and the receiver is disarmed. A `rx_rearm` pulse given while disabled is lost, and no frame completes while disabled.
- R12: A `rx_rearm` pulse in the cycle where a frame completes counts as arming, so that frame is loaded.
- R13: After a frame, a new start bit is recognised only once the line has been seen high. A line held low (break) yields no further frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receive enable; low idles the receiver and clears flags |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| serial_in | input | 1 | Serial line, idle high |
| seven_bit | input | 1 | 1 selects 7 data bits |
| parity_en | input | 1 | 1 adds and checks a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| rx_rearm | input | 1 | One-cycle strobe arming the holding register |
| clr_overrun | input | 1 | Write-1 clear of `overrun_err` |
| clr_parity | input | 1 | Write-1 clear of `parity_err` |
| clr_framing | input | 1 | Write-1 clear of `framing_err` |
| rx_data | output | DATA_MAX | Last byte accepted |
| rx_done | output | 1 | One-cycle frame-complete pulse |
| overrun_err | output | 1 | Sticky overrun flag |
| parity_err | output | 1 | Sticky parity flag |
| framing_err | output | 1 | Sticky framing flag |

## Verification
Two pairs of functions can meet in one cycle. The first is frame completion together with a write-1 clear of the flag that the frame is setting. The second is frame completion together with the re-arm strobe. The bench measures, once, the fixed delay from the leading edge of the start bit to `rx_done`. It then places the clear or re-arm strobe so that it is sampled on exactly the completion edge. The outcome is judged against a behavioural model that applies "set beats clear" and "re-arm in the completion cycle counts". The model compares `rx_done`, `rx_data` and every flag on each clock.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_deframer.sv
module serial_rx_deframer
  import serial_rx_pkg::*;
#(
  parameter int DATA_MAX   = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                tick,
  input  logic                line,
  input  logic                seven_bit,
  input  logic                parity_en,
  input  logic                parity_odd,
  output logic                frame_end,
  output logic [DATA_MAX-1:0] frame_data,
  output logic                frame_perr,
  output logic                frame_ferr
);
  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int IW   = $clog2(DATA_MAX);
  localparam int HALF = OVERSAMPLE / 2;
  localparam logic [CW-1:0] LAST   = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] MID    = CW'(HALF - 1);
  localparam logic [IW-1:0] IDX_8  = IW'(DATA_MAX - 1);
  localparam logic [IW-1:0] IDX_7  = IW'(DATA_MAX - 2);

  rx_state_e          state;
  logic [CW-1:0]      cnt;
  logic [IW-1:0]      idx;
  logic [DATA_MAX-1:0] shreg;
  logic               acc, pbit, idle_high;
  logic               f_seven, f_par, f_odd;
  logic               bit_point;
  logic [IW-1:0]      idx_last;

  assign bit_point  = tick && (cnt == LAST);
  assign idx_last   = f_seven ? IDX_7 : IDX_8;
  assign frame_end  = en && bit_point && (state == RX_STOP);
  assign frame_data = shreg;
  assign frame_perr = f_par && (acc ^ pbit ^ f_odd);
  assign frame_ferr = ~line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      shreg     <= '0;
      acc       <= 1'b0;
      pbit      <= 1'b0;
      idle_high <= 1'b0;
      f_seven   <= 1'b0;
      f_par     <= 1'b0;
      f_odd     <= 1'b0;
    end else if (!en) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      idle_high <= 1'b0;
    end else if (tick) begin
      unique case (state)
        RX_IDLE: begin
          if (line) idle_high <= 1'b1;
          else if (idle_high) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (cnt == MID) begin
            cnt <= '0;
            if (!line) begin
              state   <= RX_DATA;
              idx     <= '0;
              shreg   <= '0;
              acc     <= 1'b0;
              f_seven <= seven_bit;
              f_par   <= parity_en;
              f_odd   <= parity_odd;
            end else begin
              state <= RX_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (state == RX_DATA) begin
              shreg[idx] <= line;
              acc        <= acc ^ line;
              if (idx == idx_last) state <= f_par ? RX_PAR : RX_STOP;
              else                 idx   <= idx + 1'b1;
            end else if (state == RX_PAR) begin
              pbit  <= line;
              state <= RX_STOP;
            end else begin
              idle_high <= line;
              state     <= RX_IDLE;
            end
          end
        end
      endcase
    end
  end

  // R11: a disabled receiver is idle on the next cycle
  a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == RX_IDLE));
  // R13: completing a frame always returns to idle
  a_r13_end_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (state == RX_IDLE));
  // R1: a start-bit high at mid-point aborts to idle
  a_r1_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && state == RX_START && cnt == MID && line) |=> (state == RX_IDLE));
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
  parameter int DATA_MAX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                frame_end,
  input  logic [DATA_MAX-1:0] frame_data,
  input  logic                frame_perr,
  input  logic                frame_ferr,
  input  logic                rearm,
  input  logic                clr_ovr,
  input  logic                clr_par,
  input  logic                clr_frm,
  output logic [DATA_MAX-1:0] hold_q,
  output logic                done_q,
  output logic                ovr_q,
  output logic                par_q,
  output logic                frm_q
);
  logic armed, arm_eff, take;

  assign arm_eff = armed | rearm;
  assign take    = en & frame_end & arm_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      par_q  <= 1'b0;
      frm_q  <= 1'b0;
    end else if (!en) begin
      armed  <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      par_q  <= 1'b0;
      frm_q  <= 1'b0;
    end else begin
      armed  <= frame_end ? 1'b0 : arm_eff;
      done_q <= frame_end;
      ovr_q  <= (frame_end & ~arm_eff)   | (ovr_q & ~clr_ovr);
      par_q  <= (frame_end & frame_perr) | (par_q & ~clr_par);
      frm_q  <= (frame_end & frame_ferr) | (frm_q & ~clr_frm);
    end
  end

  always_ff @(posedge clk) begin
    if (take) hold_q <= frame_data;
  end

  // R6: completion pulse never lasts two cycles
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7 / R12: armed completion loads the byte and consumes the arming
  a_r7_load_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_end && (armed || rearm)) |=> (hold_q == $past(frame_data)) && !armed);
  // R8: unarmed completion raises overrun and keeps the older byte
  a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_end && !armed && !rearm) |=> ovr_q && $stable(hold_q));
  // R10: a framing error set wins over a same-cycle clear
  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_end && frame_ferr) |=> frm_q);
  // R9: a clear with no competing event drops the parity flag
  a_r9_clear_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_par && !(frame_end && frame_perr)) |=> !par_q);
  // R11: disabling clears every flag and the arming
  a_r11_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ovr_q && !par_q && !frm_q && !armed);
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags #(
  parameter int DATA_MAX    = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_enable,
  input  logic                baud_tick,
  input  logic                serial_in,
  input  logic                seven_bit,
  input  logic                parity_en,
  input  logic                parity_odd,
  input  logic                rx_rearm,
  input  logic                clr_overrun,
  input  logic                clr_parity,
  input  logic                clr_framing,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_done,
  output logic                overrun_err,
  output logic                parity_err,
  output logic                framing_err
);
  logic                line_s;
  logic                f_end, f_perr, f_ferr;
  logic [DATA_MAX-1:0] f_data;

  serial_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(serial_in), .q(line_s)
  );

  serial_rx_deframer #(.DATA_MAX(DATA_MAX), .OVERSAMPLE(OVERSAMPLE)) u_deframer (
    .clk(clk), .rst_n(rst_n), .en(rx_enable), .tick(baud_tick), .line(line_s),
    .seven_bit(seven_bit), .parity_en(parity_en), .parity_odd(parity_odd),
    .frame_end(f_end), .frame_data(f_data), .frame_perr(f_perr), .frame_ferr(f_ferr)
  );

  serial_rx_status #(.DATA_MAX(DATA_MAX)) u_status (
    .clk(clk), .rst_n(rst_n), .en(rx_enable),
    .frame_end(f_end), .frame_data(f_data), .frame_perr(f_perr), .frame_ferr(f_ferr),
    .rearm(rx_rearm), .clr_ovr(clr_overrun), .clr_par(clr_parity), .clr_frm(clr_framing),
    .hold_q(rx_data), .done_q(rx_done), .ovr_q(overrun_err), .par_q(parity_err),
    .frm_q(framing_err)
  );
endmodule

// File: tb/serial_rx_flags_tb_top.sv
module serial_rx_flags_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_enable = 1'b0, baud_tick = 1'b0, serial_in = 1'b1;
  logic seven_bit = 1'b0, parity_en = 1'b0, parity_odd = 1'b0;
  logic rx_rearm = 1'b0, clr_overrun = 1'b0, clr_parity = 1'b0, clr_framing = 1'b0;
  logic [7:0] rx_data;
  logic rx_done, overrun_err, parity_err, framing_err;

  serial_rx_flags dut_i (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .baud_tick(baud_tick),
    .serial_in(serial_in), .seven_bit(seven_bit), .parity_en(parity_en),
    .parity_odd(parity_odd), .rx_rearm(rx_rearm), .clr_overrun(clr_overrun),
    .clr_parity(clr_parity), .clr_framing(clr_framing), .rx_data(rx_data),
    .rx_done(rx_done), .overrun_err(overrun_err), .parity_err(parity_err),
    .framing_err(framing_err)
  );

  always #10 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0, done_cnt = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    #5 baud_tick = (cyc % 4 == 0);
  end

  // inputs as seen by the design at the latest edge
  logic s_en, s_rearm, s_cov, s_cpar, s_cfrm;
  always @(posedge clk) begin
    s_en <= rx_enable; s_rearm <= rx_rearm;
    s_cov <= clr_overrun; s_cpar <= clr_parity; s_cfrm <= clr_framing;
  end

  typedef struct { int at; logic [7:0] data; bit perr; bit ferr; } ev_t;
  ev_t evq[$];
  int  base = -1, cal_start = 0, cal_bits = 0;
  bit  cal_pend = 1'b0;

  logic [7:0] m_data;
  bit m_dv, m_armed, m_ovr, m_par, m_frm, exp_done;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle reference model
  always @(negedge clk) begin
    if (!rst_n) begin
      m_dv = 0; m_armed = 0; m_ovr = 0; m_par = 0; m_frm = 0;
    end else begin
      bit ev;
      ev_t e;
      if (rx_done) done_cnt++;
      if (cal_pend && rx_done) begin
        base = cyc - cal_start - cal_bits * 64;
        evq[0].at = cyc;
        cal_pend = 0;
        chk("R6 done delay in stop-bit window", int'(base >= 88 && base <= 112), 1);
      end
      ev = (evq.size() > 0) && (evq[0].at == cyc);
      exp_done = 0;
      if (!s_en) begin
        m_armed = 0; m_ovr = 0; m_par = 0; m_frm = 0;
      end else begin
        if (ev) begin
          e = evq.pop_front();
          exp_done = 1;
          if (m_armed || s_rearm) begin
            m_data = e.data; m_dv = 1; m_armed = 0;
            m_ovr = m_ovr && !s_cov;
          end else begin
            m_ovr = 1;
          end
          m_par = e.perr ? 1'b1 : (m_par && !s_cpar);
          m_frm = e.ferr ? 1'b1 : (m_frm && !s_cfrm);
        end else begin
          m_armed = m_armed || s_rearm;
          m_ovr = m_ovr && !s_cov;
          m_par = m_par && !s_cpar;
          m_frm = m_frm && !s_cfrm;
        end
      end
      chk("R6 rx_done", int'(rx_done), int'(exp_done));
      chk("R8 overrun_err", int'(overrun_err), int'(m_ovr));
      chk("R4 parity_err", int'(parity_err), int'(m_par));
      chk("R5 framing_err", int'(framing_err), int'(m_frm));
      if (m_dv) chk("R2 rx_data", int'(rx_data), int'(m_data));
    end
  end

  task automatic hold(input int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic pulse(input int sel);
    case (sel)
      1: rx_rearm = 1; 2: clr_framing = 1; 3: clr_parity = 1; 4: clr_overrun = 1;
      default: ;
    endcase
    hold(1);
    rx_rearm = 0; clr_framing = 0; clr_parity = 0; clr_overrun = 0;
  endtask

  // sel: 0 none, 1 rearm, 2 clr framing, 3 clr parity, 4 clr overrun (in completion cycle)
  task automatic send_frame(input logic [7:0] d, input bit stop_v, input bit bad_par,
                            input int sel, input bit expect_ev, input bit tail_low);
    int nb, tot, start, at_cyc;
    logic p;
    ev_t e;
    nb  = seven_bit ? 7 : 8;
    tot = nb + (parity_en ? 1 : 0);
    do hold(1); while (cyc % 4 != 0);
    serial_in = 0;
    start = cyc;
    p = ^(seven_bit ? (d & 8'h7f) : d);
    e.data = seven_bit ? {1'b0, d[6:0]} : d;
    e.perr = parity_en && bad_par;
    e.ferr = !stop_v;
    at_cyc = (base >= 0) ? start + base + tot * 64 : -1;
    e.at = at_cyc;
    if (expect_ev) begin
      if (base < 0) begin cal_pend = 1; cal_start = start; cal_bits = tot; end
      evq.push_back(e);
    end
    hold(64);
    for (int i = 0; i < nb; i++) begin serial_in = d[i]; hold(64); end
    if (parity_en) begin serial_in = p ^ parity_odd ^ bad_par; hold(64); end
    serial_in = stop_v;
    for (int j = 0; j < 64; j++) begin
      if (sel != 0 && cyc == at_cyc - 1) begin
        case (sel)
          1: rx_rearm = 1; 2: clr_framing = 1; 3: clr_parity = 1; 4: clr_overrun = 1;
          default: ;
        endcase
      end else begin
        rx_rearm = 0; clr_framing = 0; clr_parity = 0; clr_overrun = 0;
      end
      hold(1);
    end
    rx_rearm = 0; clr_framing = 0; clr_parity = 0; clr_overrun = 0;
    if (tail_low) begin serial_in = 0; hold(200); end
    serial_in = 1;
    hold(32);
  endtask

  initial begin
    int c0;
    repeat (5) @(posedge clk);
    #5 rst_n = 1; rx_enable = 1;
    @(negedge clk);
    chk("R11 reset flags", int'({overrun_err, parity_err, framing_err, rx_done}), 0);
    hold(40);

    pulse(1);
    c0 = done_cnt;
    send_frame(8'hA5, 1, 0, 0, 1, 0);
    chk("R2 8-bit byte", int'(rx_data), 'hA5);
    chk("R6 one pulse per frame", done_cnt - c0, 1);

    send_frame(8'h3C, 1, 0, 0, 1, 0);
    chk("R7 arming consumed, overrun", int'(overrun_err), 1);
    chk("R8 older byte kept", int'(rx_data), 'hA5);
    hold(20);
    chk("R9 flag sticky with no clear", int'(overrun_err), 1);
    pulse(4); @(negedge clk);
    chk("R9 overrun cleared by write 1", int'(overrun_err), 0);

    seven_bit = 1;
    pulse(1); send_frame(8'hFF, 1, 0, 0, 1, 0);
    chk("R3 7-bit top bit zero", int'(rx_data), 'h7F);

    parity_en = 1;
    pulse(1); send_frame(8'hD3, 1, 0, 0, 1, 0);
    chk("R3 7-bit parity byte", int'(rx_data), 'h53);
    chk("R4 even parity ok", int'(parity_err), 0);

    seven_bit = 0; parity_odd = 1;
    pulse(1); send_frame(8'h81, 1, 0, 0, 1, 0);
    chk("R4 odd parity ok", int'(parity_err), 0);
    chk("R4 odd parity byte", int'(rx_data), 'h81);
    pulse(1); send_frame(8'h5A, 1, 1, 0, 1, 0);
    chk("R4 odd parity mismatch", int'(parity_err), 1);
    chk("R4 byte still delivered", int'(rx_data), 'h5A);
    pulse(3); @(negedge clk);
    chk("R9 parity cleared", int'(parity_err), 0);

    parity_en = 0; parity_odd = 0;
    pulse(1);
    c0 = done_cnt;
    send_frame(8'h00, 0, 0, 0, 1, 1);
    chk("R5 framing error", int'(framing_err), 1);
    chk("R13 break gives one frame", done_cnt - c0, 1);
    pulse(2); @(negedge clk);
    chk("R9 framing cleared", int'(framing_err), 0);

    pulse(1); send_frame(8'h10, 0, 0, 2, 1, 0);
    chk("R10 set beats same-cycle clear", int'(framing_err), 1);
    pulse(2);

    send_frame(8'hC7, 1, 0, 1, 1, 0);
    chk("R12 rearm in completion cycle loads", int'(rx_data), 'hC7);
    chk("R12 no overrun", int'(overrun_err), 0);

    c0 = done_cnt;
    serial_in = 0; hold(6); serial_in = 1; hold(200);
    chk("R1 short low pulse ignored", done_cnt - c0, 0);

    send_frame(8'h3C, 1, 0, 0, 1, 0);
    chk("R8 overrun before disable", int'(overrun_err), 1);
    c0 = done_cnt;
    fork
      send_frame(8'h00, 1, 0, 0, 0, 0);
      begin
        hold(300); rx_enable = 0; hold(2);
        chk("R11 flags zero while disabled", int'(overrun_err), 0);
        pulse(1); hold(10); rx_enable = 1;
      end
    join
    chk("R11 no frame after disable", done_cnt - c0, 0);
    send_frame(8'h66, 1, 0, 0, 1, 0);
    chk("R11 rearm while disabled lost", int'(overrun_err), 1);
    chk("R11 byte unchanged", int'(rx_data), 'hC7);

    hold(20);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule